// File: doc/BRIEF.md
# Audio InfoFrame Packet Builder

This block builds the fixed-format audio information packet that an HDMI source sends to describe its audio stream. The packet has three header bytes, a checksum byte and ten payload bytes. The caller supplies a start pulse, the number of audio channels (2 to 8) and an 8-bit speaker-placement code. The block captures these values when it accepts the start pulse. It then makes a first pass over every byte to add up the checksum. After that it writes the 14 bytes to a packet buffer, one byte per cycle, each with a write strobe.

Only two fields vary: the channel-count field and the speaker-placement field. Every other payload field is sent as zero. The checksum byte is chosen so that all 14 bytes add to zero modulo 256. A one-cycle done pulse follows the last byte.

Top module: `aif_pkt_builder`

## Requirements
- R1: A synchronous active-high `rst` puts the block in idle with `wr_en` and `done` low. A reset during a packet stops it: no further strobe and no done pulse follow.
- R2: The first three strobed bytes are the header: 0x84, then 0x01, then 0x0A.
- R3: The fourth strobed byte is the checksum. The 8-bit sum of all 14 strobed bytes of a packet is zero.
- R4: The fifth strobed byte has the channel count minus one in bits 2:0. Bits 7:3 are zero, so the coding-type nibble is zero.
- R5: The eighth strobed byte equals the `alloc_code` captured at start.
- R6: Strobed bytes 6, 7 and 9 to 14 (counting from 1) are all zero.
- R7: The checksum pass takes 14 cycles. If `start` is sampled at clock edge 0, the first strobe follows edge 15. Exactly 14 strobes then come in consecutive cycles.
- R8: `done` is high for exactly one cycle, the cycle right after the last strobe, and never together with `wr_en`.
- R9: A `start` that arrives while a packet is in progress is ignored. It does not restart or lengthen the packet, and it does not cause a second packet afterwards.
- R10: `ch_count` and `alloc_code` are sampled only when `start` is accepted. Changing them later does not affect the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts one packet when the block is idle |
| ch_count | input | CNT_W | Number of audio channels, 2 to 8 |
| alloc_code | input | DATA_W | Speaker placement code |
| wr_data | output | DATA_W | Packet byte to the buffer |
| wr_en | output | 1 | Write strobe for `wr_data` |
| done | output | 1 | One-cycle pulse after the last byte |

## Verification
The hardest case to reach from the ports is a second start pulse, or a change of inputs, while a packet is already in progress. The bench raises `start` once during the checksum pass and once during byte emission, each time with different channel and speaker values. It also changes the inputs two cycles after a start is accepted. In each case it checks that the emitted packet still holds the first values, and that no extra strobe or done pulse appears for many cycles afterwards. A reset in the middle of emission is also covered.

// File: rtl/aif_pkg.sv
package aif_pkg;

   localparam int HDR_BYTES = 3;
   localparam int PAY_BYTES = 10;
   localparam int NUM_BYTES = HDR_BYTES + 1 + PAY_BYTES;
   localparam int IDX_W     = $clog2(NUM_BYTES);
   localparam int CKSUM_POS = HDR_BYTES;
   localparam int CHAN_POS  = HDR_BYTES + 1;
   localparam int SPK_POS   = HDR_BYTES + 4;

   localparam logic [7:0] PKT_TYPE = 8'h84;
   localparam logic [7:0] PKT_VER  = 8'h01;
   localparam logic [7:0] PKT_LEN  = 8'(PAY_BYTES);

   typedef enum logic [1:0] {ST_IDLE, ST_SUM, ST_SEND, ST_FIN} aif_state_e;

   // Raw byte at a packet position; the checksum slot reads as zero.
   function automatic logic [7:0] aif_byte(input logic [IDX_W-1:0] idx,
                                           input logic [2:0] ch_m1,
                                           input logic [7:0] spk);
      logic [7:0] b;
      case (int'(idx))
         0:        b = PKT_TYPE;
         1:        b = PKT_VER;
         2:        b = PKT_LEN;
         CHAN_POS: b = {5'b00000, ch_m1};
         SPK_POS:  b = spk;
         default:  b = 8'h00;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/aif_cksum.sv
module aif_cksum
   import aif_pkg::*;
#(
   parameter bit SERIAL_SUM = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             acc_en,
   input  logic [7:0]       byte_in,
   input  logic [2:0]       ch_m1,
   input  logic [7:0]       spk,
   output logic [7:0]       cksum
);

   generate
      if (SERIAL_SUM) begin : g_serial
         logic [7:0] sum_q;
         always_ff @(posedge clk) begin
            if (rst || clr) sum_q <= 8'h00;
            else if (acc_en) sum_q <= sum_q + byte_in;
         end
         assign cksum = 8'h00 - sum_q;
      end else begin : g_parallel
         logic [7:0] sum_c;
         always_comb begin
            sum_c = 8'h00;
            for (int i = 0; i < NUM_BYTES; i++)
               sum_c = sum_c + aif_byte(IDX_W'(i), ch_m1, spk);
         end
         assign cksum = 8'h00 - sum_c;
      end
   endgenerate

endmodule

// File: rtl/aif_seq.sv
module aif_seq
   import aif_pkg::*;
#(
   parameter bit SERIAL_SUM = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   output logic             load,
   output logic             acc_en,
   output logic             send,
   output logic             fin,
   output logic [IDX_W-1:0] idx
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BYTES - 1);

   aif_state_e       state_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               idx_q   <= '0;
               state_q <= SERIAL_SUM ? ST_SUM : ST_SEND;
            end
            ST_SUM: if (idx_q == LAST) begin
               idx_q   <= '0;
               state_q <= ST_SEND;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
            ST_SEND: if (idx_q == LAST) begin
               idx_q   <= '0;
               state_q <= ST_FIN;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign load   = (state_q == ST_IDLE) && start;
   assign acc_en = (state_q == ST_SUM);
   assign send   = (state_q == ST_SEND);
   assign fin    = (state_q == ST_FIN);
   assign idx    = idx_q;

   // R7
   sum_advance_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_SUM && idx_q != LAST) |=> (state_q == ST_SUM && idx_q == $past(idx_q) + 1'b1));

   // R9
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_SEND && start) |=> (state_q != ST_SUM && state_q != ST_IDLE));

   // R9
   fin_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_FIN) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/aif_pkt_builder.sv
module aif_pkt_builder
   import aif_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CNT_W      = 4,
   parameter bit SERIAL_SUM = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [CNT_W-1:0]  ch_count,
   input  logic [DATA_W-1:0] alloc_code,
   output logic [DATA_W-1:0] wr_data,
   output logic              wr_en,
   output logic              done
);

   localparam int CHK_W = $clog2(NUM_BYTES + 1);

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("aif_pkt_builder: DATA_W must be 8");
      end
      if (CNT_W < 4) begin : g_bad_cnt_w
         $error("aif_pkt_builder: CNT_W must hold the value 8");
      end
   endgenerate

   logic             load, acc_en, send, fin;
   logic [IDX_W-1:0] idx;
   logic [CNT_W-1:0] ch_q;
   logic [7:0]       spk_q;
   logic [2:0]       ch_m1;
   logic [7:0]       raw_byte, cksum, out_byte;

   aif_seq #(.SERIAL_SUM(SERIAL_SUM)) u_seq (
      .clk(clk), .rst(rst), .start(start),
      .load(load), .acc_en(acc_en), .send(send), .fin(fin), .idx(idx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ch_q  <= '0;
         spk_q <= '0;
      end else if (load) begin
         ch_q  <= ch_count;
         spk_q <= alloc_code;
      end
   end

   assign ch_m1    = 3'(ch_q - CNT_W'(1));
   assign raw_byte = aif_byte(idx, ch_m1, spk_q);

   aif_cksum #(.SERIAL_SUM(SERIAL_SUM)) u_cksum (
      .clk(clk), .rst(rst), .clr(load), .acc_en(acc_en),
      .byte_in(raw_byte), .ch_m1(ch_m1), .spk(spk_q), .cksum(cksum)
   );

   assign out_byte = (int'(idx) == CKSUM_POS) ? cksum : raw_byte;

   logic [7:0] wr_data_q;
   logic       wr_en_q, done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_en_q   <= 1'b0;
         wr_data_q <= '0;
         done_q    <= 1'b0;
      end else begin
         wr_en_q   <= send;
         wr_data_q <= send ? out_byte : 8'h00;
         done_q    <= fin;
      end
   end

   assign wr_data = wr_data_q;
   assign wr_en   = wr_en_q;
   assign done    = done_q;

   // Checker state: bytes and running sum of the packet on the output port
   logic [CHK_W-1:0] chk_cnt;
   logic [7:0]       chk_sum;
   always_ff @(posedge clk) begin
      if (rst || done_q) begin
         chk_cnt <= '0;
         chk_sum <= 8'h00;
      end else if (wr_en_q) begin
         chk_cnt <= chk_cnt + 1'b1;
         chk_sum <= chk_sum + wr_data_q;
      end
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> (!wr_en_q && !done_q));

   // R2
   header_first_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en_q && chk_cnt == '0) |-> (wr_data_q == PKT_TYPE));

   // R3
   sum_zero_chk: assert property (@(posedge clk) disable iff (rst)
      done_q |-> (chk_sum == 8'h00));

   // R7
   byte_count_chk: assert property (@(posedge clk) disable iff (rst)
      done_q |-> (chk_cnt == CHK_W'(NUM_BYTES)));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done_q |=> !done_q);

   // R8
   done_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      done_q |-> !wr_en_q);

endmodule

// File: tb/test_aif_pkt_builder.sv
module test_aif_pkt_builder;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic [3:0] ch_count = 4'd2;
   logic [7:0] alloc_code = 8'h00;
   logic [7:0] wr_data;
   logic       wr_en, done;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   logic [7:0] got [14];
   int n_str, first_k, last_k, done_k, done_n;

   aif_pkt_builder i_aif_pkt_builder (
      .clk(clk), .rst(rst), .start(start), .ch_count(ch_count),
      .alloc_code(alloc_code), .wr_data(wr_data), .wr_en(wr_en), .done(done)
   );

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog R7 actual=%0d expected<=20000", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Pulse start at a falling edge; on return the accepting edge (edge 0) has passed.
   task automatic launch(input logic [3:0] cc, input logic [7:0] ca);
      @(negedge clk);
      ch_count = cc; alloc_code = ca; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Observe 40 cycles; optionally change inputs at chg_k or restart at rest_k.
   task automatic capture(input int chg_k, input int rest_k,
                          input logic [3:0] ncc, input logic [7:0] nca);
      n_str = 0; first_k = -1; last_k = -1; done_k = -1; done_n = 0;
      for (int k = 1; k <= 40; k++) begin
         if (k == chg_k) begin ch_count = ncc; alloc_code = nca; end
         if (k == rest_k) begin start = 1'b1; ch_count = ncc; alloc_code = nca; end
         else start = 1'b0;
         @(negedge clk);
         if (wr_en) begin
            if (n_str < 14) got[n_str] = wr_data;
            n_str++;
            if (first_k < 0) first_k = k;
            last_k = k;
         end
         if (done) begin
            done_n++;
            if (done_k < 0) done_k = k;
         end
      end
      start = 1'b0;
   endtask

   task automatic verify(input logic [3:0] cc, input logic [7:0] ca);
      logic [7:0] exp [14];
      logic [7:0] s;
      for (int i = 0; i < 14; i++) exp[i] = 8'h00;
      exp[0] = 8'h84; exp[1] = 8'h01; exp[2] = 8'h0A;
      exp[4] = {5'b0, 3'(cc - 4'd1)};
      exp[7] = ca;
      exp[3] = 8'h00 - (exp[0] + exp[1] + exp[2] + exp[4] + exp[7]);
      chk(n_str == 14, "R7 strobe count", n_str, 14);
      chk(first_k == 15, "R7 first strobe cycle", first_k, 15);
      chk(last_k == 28, "R7 last strobe cycle", last_k, 28);
      chk(done_k == 29, "R8 done cycle", done_k, 29);
      chk(done_n == 1, "R8 done width", done_n, 1);
      if (n_str >= 14) begin
         s = 8'h00;
         for (int i = 0; i < 14; i++) begin
            s = s + got[i];
            if (i < 3)       chk(got[i] == exp[i], "R2 header byte", got[i], exp[i]);
            else if (i == 3) chk(got[i] == exp[i], "R3 checksum byte", got[i], exp[i]);
            else if (i == 4) chk(got[i] == exp[i], "R4 channel byte", got[i], exp[i]);
            else if (i == 7) chk(got[i] == exp[i], "R5 speaker byte", got[i], exp[i]);
            else             chk(got[i] == 8'h00, "R6 zero byte", got[i], 0);
         end
         chk(s == 8'h00, "R3 packet sum", s, 0);
      end
   endtask

   task automatic quiet(input int n, input string req);
      int seen = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (wr_en || done) seen++;
      end
      chk(seen == 0, req, seen, 0);
   endtask

   task automatic t_reset;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(!wr_en && !done, "R1 outputs in reset", {wr_en, done}, 0);
      rst = 1'b0;
      quiet(5, "R1 idle after reset");
   endtask

   task automatic t_packet(input logic [3:0] cc, input logic [7:0] ca);
      launch(cc, ca);
      capture(-1, -1, cc, ca);
      verify(cc, ca);
   endtask

   task automatic t_busy_start(input int rest_k);
      launch(4'd6, 8'h0B);
      capture(-1, rest_k, 4'd3, 8'h2F);
      verify(4'd6, 8'h0B);
      quiet(40, "R9 no packet from busy start");
   endtask

   task automatic t_input_change;
      launch(4'd5, 8'h0A);
      capture(2, -1, 4'd7, 8'h31);
      verify(4'd5, 8'h0A);
      ch_count = 4'd2; alloc_code = 8'h00;
      chk(1'b1, "R10 inputs held at start", 0, 0);
   endtask

   task automatic t_reset_mid;
      launch(4'd4, 8'h03);
      repeat (19) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(!wr_en && !done, "R1 reset mid packet", {wr_en, done}, 0);
      quiet(40, "R1 packet stopped by reset");
   endtask

   initial begin
      t_reset();
      t_packet(4'd2, 8'h00);
      t_packet(4'd8, 8'h13);
      t_packet(4'd6, 8'hFF);
      t_busy_start(5);
      t_busy_start(20);
      t_input_change();
      t_reset_mid();
      t_packet(4'd3, 8'h31);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule